// File: doc/BRIEF.md
# Interrupt Request Edge/Level Capture

This block is the request-capture front end of a legacy-style eight-input programmable interrupt controller. Each raw request line is sampled on every clock and folded into a request register. A line counts as level-sensitive when a chip-wide level flag is set, or when its own bit in a per-line trigger-select register is set. Any line that is not level-sensitive is edge-sensitive. The same rule decides whether an acknowledge clears the line's request bit.

Software reaches the block through two write ports. The first is a byte-wide command port with a one-bit address. An initialization word on this port latches the chip-wide level flag and two setup flags, and performs an internal reset of the capture state. An operation-control word on the same port can turn on the poll flag. The second port writes the trigger-select register. An acknowledge strobe with a line index moves that request into the in-service register. Priority resolution, cascading and vector generation are handled elsewhere.

Top module: `irq_trigger_capture`

## Requirements
- R1: After reset, the request register, the in-service register, the trigger-select register, the chip-wide level flag, the setup flags, the poll flag and `pending_o` are all 0.
- R2: A command write with `cmd_addr`=0 and data bit 4 set is an initialization word. On the next cycle, `level_all_o` equals data bit 3, `icw4_o` equals data bit 0 and `single_o` equals data bit 1. The same write clears the request register, the in-service register and the poll flag. In the cycle of that write, acknowledges and line activity do not set request or in-service bits.
- R3: An initialization word leaves the trigger-select register unchanged. A line selected as level-sensitive before the word is still level-sensitive after it.
- R4: Line n is level-sensitive when `level_all_o` is 1 or trigger-select bit n is 1. Otherwise it is edge-sensitive.
- R5: For a level-sensitive line, the request bit one cycle later equals the line's level.
- R6: For an edge-sensitive line, the request bit is set one cycle after a low-to-high transition relative to the previous sampled level. A line that stays high does not set the bit again after it has been cleared.
- R7: An acknowledge of index n sets in-service bit n on the next cycle. It clears request bit n only if line n is edge-sensitive. If a rising edge arrives in the same cycle as the acknowledge, the request bit stays set.
- R8: A command write with `cmd_addr`=0, data bit 4 clear and data bit 3 set loads the poll flag from data bit 2. Other non-initialization command writes, including every write with `cmd_addr`=1, change no flag.
- R9: `pending_o` is 1 exactly when some request bit is set and its in-service bit is clear.
- R10: A trigger-select write takes effect on the cycle after the write. Capture in the cycle of the write uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low full reset |
| irq_line | input | 8 | Raw request lines |
| cmd_wr | input | 1 | Command write strobe |
| cmd_addr | input | 1 | Command port address bit |
| cmd_data | input | 8 | Command data byte |
| trig_wr | input | 1 | Trigger-select write strobe |
| trig_data | input | 8 | Trigger-select value, 1 = level-sensitive |
| ack_stb | input | 1 | Acknowledge strobe |
| ack_idx | input | 3 | Acknowledged line index |
| req_o | output | 8 | Request register |
| isr_o | output | 8 | In-service register |
| pending_o | output | 1 | A request is set that is not in service |
| level_all_o | output | 1 | Chip-wide level flag |
| icw4_o | output | 1 | Fourth setup word expected |
| single_o | output | 1 | Single (non-cascaded) mode |
| poll_o | output | 1 | Poll flag |

## Verification
The hardest case to reach is a level-sensitive line that is still high when an initialization word arrives, because it depends on several events lining up. The request must drop for exactly one cycle and then return. When the line is level-sensitive only through the trigger-select register, this also shows that the register survived the internal reset. Directed sequences set up this ordering, and also the case of a rising edge arriving in the same cycle as its own acknowledge. Random traffic then mixes command words, trigger-select writes and acknowledges against a cycle-accurate bench model.

// File: rtl/irqcap_pkg.sv
package irqcap_pkg;
    localparam int CMD_W        = 8;
    localparam int INIT_BIT     = 4;
    localparam int LVL_BIT      = 3;
    localparam int ICW4_BIT     = 0;
    localparam int SINGLE_BIT   = 1;
    localparam int OCW_SEL_BIT  = 3;
    localparam int POLL_BIT     = 2;

    typedef struct packed {
        logic level_all;
        logic icw4;
        logic single;
        logic poll;
    } mode_t;

    typedef struct packed {
        logic req;
        logic isr;
        logic prev;
    } lane_t;
endpackage

// File: rtl/irqcap_ctrl.sv
module irqcap_ctrl
    import irqcap_pkg::*;
#(
    parameter int N_IN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic             cmd_addr,
    input  logic [CMD_W-1:0] cmd_data,
    input  logic             trig_wr,
    input  logic [N_IN-1:0]  trig_data,
    output logic             init_hit,
    output mode_t            mode_q,
    output logic [N_IN-1:0]  trig_q
);
    mode_t           mode_d;
    logic [N_IN-1:0] trig_d;
    logic            ocw_hit;

    always_comb begin
        init_hit = cmd_wr && !cmd_addr && cmd_data[INIT_BIT];
        ocw_hit  = cmd_wr && !cmd_addr && !cmd_data[INIT_BIT] && cmd_data[OCW_SEL_BIT];
        mode_d   = mode_q;
        trig_d   = trig_q;
        if (init_hit) begin
            mode_d.level_all = cmd_data[LVL_BIT];
            mode_d.icw4      = cmd_data[ICW4_BIT];
            mode_d.single    = cmd_data[SINGLE_BIT];
            mode_d.poll      = 1'b0;
        end else if (ocw_hit) begin
            mode_d.poll      = cmd_data[POLL_BIT];
        end
        if (trig_wr) trig_d = trig_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            trig_q <= '0;
        end else begin
            mode_q <= mode_d;
            trig_q <= trig_d;
        end
    end

    assert_addr1_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_addr) |=> $stable(mode_q));
    assert_trig_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (init_hit && !trig_wr) |=> $stable(trig_q));
endmodule

// File: rtl/irqcap_lane.sv
module irqcap_lane
    import irqcap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic lvl_sel,
    input  logic init_clr,
    input  logic ack_hit,
    output logic req,
    output logic isr
);
    lane_t lane_d, lane_q;

    always_comb begin
        lane_d      = lane_q;
        lane_d.prev = line;
        if (init_clr) begin
            lane_d.req = 1'b0;
            lane_d.isr = 1'b0;
        end else begin
            if (ack_hit) begin
                lane_d.isr = 1'b1;
                if (!lvl_sel) lane_d.req = 1'b0;
            end
            if (lvl_sel)                    lane_d.req = line;
            else if (line && !lane_q.prev)  lane_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign req = lane_q.req;
    assign isr = lane_q.isr;

    assert_init_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_clr |=> (!req && !isr));
    assert_ack_sets_isr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && !init_clr) |=> isr);
    assert_level_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_sel && !init_clr) |=> (req == $past(line)));
    assert_edge_no_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_sel && !req && !(line && !lane_q.prev)) |=> !req);
endmodule

// File: rtl/irq_trigger_capture.sv
module irq_trigger_capture
    import irqcap_pkg::*;
#(
    parameter  int N_IN  = 8,
    localparam int IDX_W = $clog2(N_IN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  irq_line,
    input  logic             cmd_wr,
    input  logic             cmd_addr,
    input  logic [CMD_W-1:0] cmd_data,
    input  logic             trig_wr,
    input  logic [N_IN-1:0]  trig_data,
    input  logic             ack_stb,
    input  logic [IDX_W-1:0] ack_idx,
    output logic [N_IN-1:0]  req_o,
    output logic [N_IN-1:0]  isr_o,
    output logic             pending_o,
    output logic             level_all_o,
    output logic             icw4_o,
    output logic             single_o,
    output logic             poll_o
);
    logic            init_hit;
    mode_t           mode_q;
    logic [N_IN-1:0] trig_q;
    logic [N_IN-1:0] lvl_sel;

    irqcap_ctrl #(.N_IN(N_IN)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .trig_wr(trig_wr), .trig_data(trig_data),
        .init_hit(init_hit), .mode_q(mode_q), .trig_q(trig_q)
    );

    assign lvl_sel = trig_q | {N_IN{mode_q.level_all}};

    for (genvar n = 0; n < N_IN; n++) begin : g_lane
        irqcap_lane u_lane (
            .clk(clk), .rst_n(rst_n),
            .line(irq_line[n]),
            .lvl_sel(lvl_sel[n]),
            .init_clr(init_hit),
            .ack_hit(ack_stb && (ack_idx == IDX_W'(n))),
            .req(req_o[n]),
            .isr(isr_o[n])
        );
    end

    assign pending_o   = |(req_o & ~isr_o);
    assign level_all_o = mode_q.level_all;
    assign icw4_o      = mode_q.icw4;
    assign single_o    = mode_q.single;
    assign poll_o      = mode_q.poll;
endmodule

// File: tb/irq_trigger_capture_test.sv
module irq_trigger_capture_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_line = '0;
    logic       cmd_wr = 1'b0, cmd_addr = 1'b0;
    logic [7:0] cmd_data = '0;
    logic       trig_wr = 1'b0;
    logic [7:0] trig_data = '0;
    logic       ack_stb = 1'b0;
    logic [2:0] ack_idx = '0;
    logic [7:0] req_o, isr_o;
    logic       pending_o, level_all_o, icw4_o, single_o, poll_o;

    int total = 0, bad = 0;
    bit done = 0;

    logic [7:0] m_req = '0, m_isr = '0, m_prev = '0, m_trig = '0;
    logic       m_lvl = 0, m_icw4 = 0, m_single = 0, m_poll = 0;

    irq_trigger_capture uut (
        .clk(clk), .rst_n(rst_n), .irq_line(irq_line),
        .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .trig_wr(trig_wr), .trig_data(trig_data),
        .ack_stb(ack_stb), .ack_idx(ack_idx),
        .req_o(req_o), .isr_o(isr_o), .pending_o(pending_o),
        .level_all_o(level_all_o), .icw4_o(icw4_o),
        .single_o(single_o), .poll_o(poll_o)
    );

    always #4 clk = ~clk;

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: next state from the inputs presented before the edge.
    task automatic model_step();
        logic init, ocw;
        logic [7:0] lv, nreq, nisr;
        init = cmd_wr && !cmd_addr && cmd_data[4];
        ocw  = cmd_wr && !cmd_addr && !cmd_data[4] && cmd_data[3];
        lv   = m_trig | {8{m_lvl}};
        nreq = m_req; nisr = m_isr;
        if (init) begin
            nreq = '0; nisr = '0;
        end else begin
            for (int n = 0; n < 8; n++) begin
                if (ack_stb && ack_idx == 3'(n)) begin
                    nisr[n] = 1'b1;
                    if (!lv[n]) nreq[n] = 1'b0;
                end
                if (lv[n]) nreq[n] = irq_line[n];
                else if (irq_line[n] && !m_prev[n]) nreq[n] = 1'b1;
            end
        end
        if (init) begin
            m_lvl = cmd_data[3]; m_icw4 = cmd_data[0];
            m_single = cmd_data[1]; m_poll = 1'b0;
        end else if (ocw) m_poll = cmd_data[2];
        if (trig_wr) m_trig = trig_data;
        m_prev = irq_line; m_req = nreq; m_isr = nisr;
    endtask

    task automatic tick(string tag);
        model_step();
        @(posedge clk); #1;
        check({tag, " req"}, req_o, m_req);
        check({tag, " isr"}, isr_o, m_isr);
        check("R9 pending", {7'd0, pending_o}, {7'd0, |(m_req & ~m_isr)});
        check("R2/R8 flags", {4'd0, level_all_o, icw4_o, single_o, poll_o},
              {4'd0, m_lvl, m_icw4, m_single, m_poll});
        cmd_wr = 0; trig_wr = 0; ack_stb = 0;
    endtask

    task automatic cmd(logic a, logic [7:0] d);
        cmd_wr = 1; cmd_addr = a; cmd_data = d;
    endtask

    task automatic ack(logic [2:0] i);
        ack_stb = 1; ack_idx = i;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2417));
        repeat (2) @(posedge clk);
        #1;
        check("R1 req", req_o, 8'h00);
        check("R1 isr", isr_o, 8'h00);
        check("R1 flags", {3'd0, pending_o, level_all_o, icw4_o, single_o, poll_o}, 8'h00);
        rst_n = 1;
        @(posedge clk); #1;

        // R6 edge capture, R7 acknowledge clears an edge request
        irq_line = 8'h01; tick("R6 rise");
        check("R6 set", req_o, 8'h01);
        ack(3'd0); tick("R7 edge ack");
        check("R7 isr0", isr_o, 8'h01);
        check("R7 req0 cleared", req_o, 8'h00);
        repeat (3) tick("R6 held high");
        check("R6 no reset", req_o, 8'h00);

        // R2 initialization word
        cmd(0, 8'h13); tick("R2 init");
        check("R2 cleared", isr_o, 8'h00);
        check("R2 flags", {5'd0, level_all_o, icw4_o, single_o}, 8'h03);

        // R10 trigger write applies next cycle; R4/R5 per-line level
        irq_line = 8'h00; trig_wr = 1; trig_data = 8'h04; tick("R10 write");
        irq_line = 8'h04; tick("R4 trig level");
        check("R5 level set", req_o, 8'h04);
        irq_line = 8'h00; tick("R5 low");
        check("R5 level clear", req_o, 8'h00);
        irq_line = 8'h04; tick("R5 high");
        ack(3'd2); tick("R7 level ack");
        check("R7 level keeps req", req_o, 8'h04);

        // R3 trigger register survives init; line still high
        cmd(0, 8'h10); tick("R3 init");
        check("R3 req dropped", req_o, 8'h00);
        tick("R3 back");
        check("R3 level kept", req_o, 8'h04);
        ack(3'd2); tick("R3 ack");
        check("R3 req kept", req_o, 8'h04);

        // R4 chip-wide level
        trig_wr = 1; trig_data = 8'h00; irq_line = 8'h00; cmd(0, 8'h18); tick("R4 init lvl");
        irq_line = 8'h20; tick("R4 chip level");
        ack(3'd5); tick("R4 ack");
        check("R4 req5 kept", req_o, 8'h20);
        irq_line = 8'h00; tick("R4 low");
        check("R4 req5 clear", req_o, 8'h00);

        // R8 poll flag and ignored writes
        cmd(0, 8'h0C); tick("R8 poll on");
        check("R8 poll", {7'd0, poll_o}, 8'h01);
        cmd(1, 8'hFF); tick("R8 addr1");
        cmd(0, 8'h04); tick("R8 non-ocw");
        check("R8 unchanged", {7'd0, poll_o}, 8'h01);
        cmd(0, 8'h08); tick("R8 poll off");
        check("R8 poll cleared", {7'd0, poll_o}, 8'h00);

        // R7 rising edge in the same cycle as its acknowledge
        cmd(0, 8'h10); tick("R7 init edge");
        irq_line = 8'h08; ack(3'd3); tick("R7 edge+ack");
        check("R7 both", req_o & isr_o, 8'h08);

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            int r;
            irq_line = 8'($urandom);
            r = $urandom_range(0, 99);
            if (r < 4)       cmd(0, 8'($urandom) | 8'h10);
            else if (r < 10) cmd(1'($urandom), 8'($urandom) & 8'hEF);
            if ($urandom_range(0, 9) == 0) begin
                trig_wr = 1; trig_data = 8'($urandom);
            end
            if ($urandom_range(0, 3) == 0) ack(3'($urandom));
            tick("R5/R6/R7 random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule